// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Data Cache

This block is a small direct-mapped data cache that sits between a processor load/store port and a slow memory port. With default parameters it holds 1 KB as 32 lines of 32 bytes. Every line is cut into four 8-byte sub-blocks. The four sub-blocks share one tag, and each sub-block has its own valid bit. A lookup hits only when the tag matches and the addressed sub-block is valid.

A read miss fetches the whole line from memory, one 8-byte sub-block per memory beat, and then answers the processor. Writes always go through to memory as a single beat. A write that lands on a line holding a different tag claims the line for the new tag, but only the sub-block just written becomes valid. This keeps the fill cost of a write miss down to one beat.

The processor holds its request until `cpu_ready` pulses. The memory side holds `mem_req` until `mem_ack` pulses, and each acknowledge moves one beat.

Top module: `sbc_cache`

## Requirements
- R1: After reset every sub-block valid bit is clear, `cpu_ready` and `mem_req` are low, and the first read of any address is a miss.
- R2: The address splits into byte offset bits [4:0], line index bits [9:5] and tag bits [31:10]. Two addresses with the same index and different tags replace each other, so alternating reads of them both miss.
- R3: A read hits when the stored tag equals the address tag and the valid bit of sub-block bits [4:3] is set. A hit raises `cpu_ready` in the cycle the request is presented, returns the stored 8 bytes, and makes no memory access.
- R4: A read miss issues exactly four memory read beats for the line, with sub-block numbers 0, 1, 2, 3 in that order. Each beat's `mem_addr` carries the sub-block number in bits [4:3] and zero in bits [2:0].
- R5: On a read miss, `cpu_ready` rises in the cycle after the fourth beat is acknowledged. It returns the requested sub-block, including when that is the last sub-block filled.
- R6: After a read miss all four sub-blocks of the line are valid, so reads of the line's other sub-blocks hit.
- R7: Every write makes exactly one memory write beat, hit or miss. The beat has `mem_addr` equal to `cpu_addr` with bits [2:0] cleared and `mem_wdata` equal to `cpu_wdata`. `cpu_ready` rises in the cycle after that beat's acknowledge.
- R8: A write whose tag differs from the line's tag loads the new tag and marks only the written sub-block valid. A later read of that sub-block hits with the written data. A read of any other sub-block of the line misses.
- R9: A write whose tag matches the line's tag stores the data and marks the written sub-block valid. The valid bits of the other sub-blocks stay as they were.
- R10: While a read fill or a write beat is in progress, `cpu_ready` stays low and no new request is taken.
- R11: Address bits [2:0] play no part in the hit decision or in data selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 64 | Write data (one sub-block) |
| cpu_ready | output | 1 | Request complete (hit or end of miss) |
| cpu_rdata | output | 64 | Read data, valid while `cpu_ready` for a read |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | 32 | Sub-block-aligned memory address |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Beat acknowledge, one cycle per beat |
| mem_rdata | input | 64 | Memory read data, valid with `mem_ack` |

## Verification
Two events meet at the same clock edge on a read miss. The acknowledge of the final fill beat writes sub-block 3 into the data store. At that same edge, the controller moves to the response cycle, which reads the requested word back out of that store. The bench provokes this by reading a sub-block 3 address on a cold line. It then compares the returned word against its own memory model, so stale data from the missing final write would show up as a mismatch. A second overlap happens when a write acknowledge updates the tag and valid bits while the response is pending. The bench judges it by reading the same sub-block straight after the write and demanding a zero-latency hit with the new data and no memory beat.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_WRITE = 2'd2,
      ST_RESP  = 2'd3
   } sbc_state_t;

endpackage

// File: rtl/sbc_addr_split.sv
module sbc_addr_split #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 5,
   parameter int IDX_W  = 5,
   parameter int SOFS_W = 3
) (
   input  logic [ADDR_W-1:0]             addr,
   output logic [ADDR_W-OFS_W-IDX_W-1:0] tag,
   output logic [IDX_W-1:0]              idx,
   output logic [OFS_W-SOFS_W-1:0]       sub
);
   assign tag = addr[ADDR_W-1:OFS_W+IDX_W];
   assign idx = addr[OFS_W+IDX_W-1:OFS_W];
   assign sub = addr[OFS_W-1:SOFS_W];
endmodule

// File: rtl/sbc_tag_store.sv
module sbc_tag_store #(
   parameter int LINES = 32,
   parameter int IDX_W = 5,
   parameter int TAG_W = 22,
   parameter int SUBS  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic [SUBS-1:0]  rd_valid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [SUBS-1:0]  wr_valid
);
   logic [TAG_W-1:0] tag_flat [LINES];
   logic [SUBS-1:0]  vld_flat [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [TAG_W-1:0] tag_q;
      logic [SUBS-1:0]  vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q <= '0;
            vld_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            tag_q <= wr_tag;
            vld_q <= wr_valid;
         end
      end

      assign tag_flat[g] = tag_q;
      assign vld_flat[g] = vld_q;
   end

   assign rd_tag   = tag_flat[rd_idx];
   assign rd_valid = vld_flat[rd_idx];
endmodule

// File: rtl/sbc_data_store.sv
module sbc_data_store #(
   parameter int LINES  = 32,
   parameter int IDX_W  = 5,
   parameter int SUBS   = 4,
   parameter int SUB_W  = 2,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [SUB_W-1:0]  rd_sub,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SUB_W-1:0]  wr_sub,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int WORDS = LINES * SUBS;

   logic [DATA_W-1:0] words [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) words[{wr_idx, wr_sub}] <= wr_data;
   end

   assign rd_data = words[{rd_idx, rd_sub}];
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
   import sbc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int OFS_W  = 5,
   parameter int SOFS_W = 3,
   parameter int TAG_W  = 22,
   parameter int SUBS   = 4,
   parameter int SUB_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [ADDR_W-1:0] look_addr,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic [SUB_W-1:0]  lk_sub,
   input  logic [TAG_W-1:0]  st_tag,
   input  logic [SUBS-1:0]   st_valid,
   output logic              tag_we,
   output logic [SUBS-1:0]   tag_wvalid,
   output logic              dat_we,
   output logic [SUB_W-1:0]  dat_sub,
   output logic [DATA_W-1:0] dat_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(SUBS - 1);

   sbc_state_t        st_q;
   logic [ADDR_W-1:0] adr_q;
   logic [DATA_W-1:0] wd_q;
   logic [SUB_W-1:0]  beat_q;

   logic            tag_eq, hit, in_fill, in_write, busy_ack;
   logic [SUBS-1:0] sub_onehot;

   assign look_addr  = (st_q == ST_IDLE) ? cpu_addr : adr_q;
   assign tag_eq     = (st_tag == lk_tag);
   assign hit        = tag_eq && st_valid[lk_sub];
   assign in_fill    = (st_q == ST_FILL);
   assign in_write   = (st_q == ST_WRITE);
   assign busy_ack   = mem_ack && (in_fill || in_write);
   assign sub_onehot = SUBS'(1) << lk_sub;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         adr_q  <= '0;
         wd_q   <= '0;
         beat_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (cpu_req && (cpu_we || !hit)) begin
                  adr_q  <= cpu_addr;
                  wd_q   <= cpu_wdata;
                  beat_q <= '0;
                  st_q   <= cpu_we ? ST_WRITE : ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == LAST_SUB) st_q <= ST_RESP;
               end
            end
            ST_WRITE: begin
               if (mem_ack) st_q <= ST_RESP;
            end
            ST_RESP: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ready = ((st_q == ST_IDLE) && cpu_req && !cpu_we && hit)
                    || (st_q == ST_RESP);

   assign mem_req   = in_fill || in_write;
   assign mem_we    = in_write;
   assign mem_wdata = wd_q;
   assign mem_addr  = in_write
                    ? {adr_q[ADDR_W-1:SOFS_W], {SOFS_W{1'b0}}}
                    : {adr_q[ADDR_W-1:OFS_W], beat_q, {SOFS_W{1'b0}}};

   assign dat_we    = busy_ack;
   assign dat_sub   = in_fill ? beat_q : lk_sub;
   assign dat_wdata = in_fill ? mem_rdata : wd_q;

   assign tag_we     = mem_ack && ((in_fill && (beat_q == LAST_SUB)) || in_write);
   assign tag_wvalid = in_fill ? {SUBS{1'b1}}
                     : (tag_eq ? (st_valid | sub_onehot) : sub_onehot);
endmodule

// File: rtl/sbc_cache.sv
module sbc_cache #(
   parameter int ADDR_W      = 32,
   parameter int CACHE_BYTES = 1024,
   parameter int LINE_BYTES  = 32,
   parameter int SUB_BYTES   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cpu_req,
   input  logic                   cpu_we,
   input  logic [ADDR_W-1:0]      cpu_addr,
   input  logic [SUB_BYTES*8-1:0] cpu_wdata,
   output logic                   cpu_ready,
   output logic [SUB_BYTES*8-1:0] cpu_rdata,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [SUB_BYTES*8-1:0] mem_wdata,
   input  logic                   mem_ack,
   input  logic [SUB_BYTES*8-1:0] mem_rdata
);
   localparam int DATA_W = SUB_BYTES * 8;
   localparam int LINES  = CACHE_BYTES / LINE_BYTES;
   localparam int SUBS   = LINE_BYTES / SUB_BYTES;
   localparam int OFS_W  = $clog2(LINE_BYTES);
   localparam int SOFS_W = $clog2(SUB_BYTES);
   localparam int IDX_W  = $clog2(LINES);
   localparam int SUB_W  = $clog2(SUBS);
   localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;

   initial begin
      assert (CACHE_BYTES == (1 << $clog2(CACHE_BYTES)))
         else $fatal(1, "cache size must be a power of two");
      assert (LINE_BYTES == (1 << OFS_W))
         else $fatal(1, "line size must be a power of two");
      assert (SUB_BYTES == (1 << SOFS_W) && SUBS >= 2)
         else $fatal(1, "need at least two power-of-two sub-blocks per line");
      assert (LINES >= 2 && TAG_W >= 1)
         else $fatal(1, "address too narrow for this geometry");
   end

   logic [ADDR_W-1:0] look_addr;
   logic [TAG_W-1:0]  lk_tag, st_tag;
   logic [IDX_W-1:0]  lk_idx;
   logic [SUB_W-1:0]  lk_sub, dat_sub;
   logic [SUBS-1:0]   st_valid, tag_wvalid;
   logic              tag_we, dat_we;
   logic [DATA_W-1:0] dat_wdata;

   sbc_addr_split #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .SOFS_W(SOFS_W)
   ) u_split (
      .addr(look_addr), .tag(lk_tag), .idx(lk_idx), .sub(lk_sub)
   );

   sbc_tag_store #(
      .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .SUBS(SUBS)
   ) u_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_tag(st_tag), .rd_valid(st_valid),
      .wr_en(tag_we), .wr_idx(lk_idx), .wr_tag(lk_tag), .wr_valid(tag_wvalid)
   );

   sbc_data_store #(
      .LINES(LINES), .IDX_W(IDX_W), .SUBS(SUBS), .SUB_W(SUB_W), .DATA_W(DATA_W)
   ) u_data (
      .clk(clk),
      .rd_idx(lk_idx), .rd_sub(lk_sub), .rd_data(cpu_rdata),
      .wr_en(dat_we), .wr_idx(lk_idx), .wr_sub(dat_sub), .wr_data(dat_wdata)
   );

   sbc_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .SOFS_W(SOFS_W),
      .TAG_W(TAG_W), .SUBS(SUBS), .SUB_W(SUB_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .look_addr(look_addr), .lk_tag(lk_tag), .lk_sub(lk_sub),
      .st_tag(st_tag), .st_valid(st_valid),
      .tag_we(tag_we), .tag_wvalid(tag_wvalid),
      .dat_we(dat_we), .dat_sub(dat_sub), .dat_wdata(dat_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );
endmodule

// File: rtl/sbc_cache_chk.sv
module sbc_cache_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int SUB_BYTES  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack
);
   localparam int OFS_W  = $clog2(LINE_BYTES);
   localparam int SOFS_W = $clog2(SUB_BYTES);
   localparam int SUB_W  = OFS_W - SOFS_W;
   localparam logic [SUB_W-1:0] LAST_SUB = '1;

   logic [SUB_W-1:0] beat;
   assign beat = mem_addr[OFS_W-1:SOFS_W];

   // R4: a fill starts at sub-block 0
   assert_fill_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_req) && !mem_we) |-> (beat == '0));

   // R4: each acknowledged non-final fill beat is followed by the next sub-block
   assert_fill_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack && (beat != LAST_SUB))
      |=> (mem_req && !mem_we && (beat == $past(beat) + 1'b1)));

   // R5: the processor is answered right after the last fill beat
   assert_fill_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack && (beat == LAST_SUB)) |=> cpu_ready);

   // R7: a write beat carries the processor address, sub-block aligned
   assert_wr_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |->
      (cpu_we && (mem_addr[ADDR_W-1:SOFS_W] == cpu_addr[ADDR_W-1:SOFS_W])
              && (mem_addr[SOFS_W-1:0] == '0)));

   // R7: the write completes the cycle after its acknowledge
   assert_wr_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (cpu_ready && !mem_req));

   // R10: nothing completes toward the processor while memory is busy
   assert_busy_no_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);
endmodule

bind sbc_cache sbc_cache_chk #(
   .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SUB_BYTES(SUB_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
   .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/sbc_cache_test.sv
module sbc_cache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [63:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [63:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [63:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;

   int checks = 0, fails = 0;
   int rd_beats = 0, wr_beats = 0, wait_cnt = 0;
   logic [31:0] rd_log [16];
   logic [31:0] last_wr_addr = '0;
   logic [63:0] last_wr_data = '0;
   logic [63:0] model [4096];
   bit          busy_ready_seen = 1'b0;

   always #10 clk = ~clk;

   sbc_cache uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory responder: acknowledges each beat after two waiting cycles
   always @(negedge clk) begin
      mem_ack = 1'b0;
      if (rst_n && mem_req) begin
         if (wait_cnt == 2) begin
            wait_cnt = 0;
            mem_ack  = 1'b1;
            if (mem_we) begin
               model[mem_addr[14:3]] = mem_wdata;
               last_wr_addr = mem_addr;
               last_wr_data = mem_wdata;
               wr_beats++;
            end else begin
               mem_rdata = model[mem_addr[14:3]];
               rd_log[rd_beats % 16] = mem_addr;
               rd_beats++;
            end
         end else wait_cnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [31:0] a,
                         input logic [63:0] wd, output logic [63:0] rd,
                         output int lat);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      lat = 0;
      #5;
      while (!cpu_ready) begin
         @(negedge clk);
         lat++;
         #5;
         if (mem_req && cpu_ready) busy_ready_seen = 1'b1;
      end
      rd = cpu_rdata;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   // read expecting a hit: zero latency, no memory beat, model data
   task automatic read_hit(input logic [31:0] a, input string req);
      logic [63:0] rd; int lat, r0;
      r0 = rd_beats;
      access(1'b0, a, '0, rd, lat);
      chk(lat == 0, req, "hit latency", 64'(lat), 64'd0);
      chk(rd_beats == r0, req, "hit memory beats", 64'(rd_beats - r0), 64'd0);
      chk(rd == model[a[14:3]], req, "hit data", rd, model[a[14:3]]);
   endtask

   // read expecting a miss: four ascending beats, model data
   task automatic read_miss(input logic [31:0] a, input string req);
      logic [63:0] rd; int lat, r0;
      r0 = rd_beats;
      access(1'b0, a, '0, rd, lat);
      chk(rd_beats - r0 == 4, req, "miss beat count", 64'(rd_beats - r0), 64'd4);
      for (int k = 0; k < 4; k++) begin
         logic [31:0] e;
         e = {a[31:5], 2'(k), 3'b000};
         chk(rd_log[(r0 + k) % 16] == e, "R4", "fill beat address",
             64'(rd_log[(r0 + k) % 16]), 64'(e));
      end
      chk(rd == model[a[14:3]], req, "miss data", rd, model[a[14:3]]);
   endtask

   task automatic write_through(input logic [31:0] a, input logic [63:0] d);
      logic [63:0] rd; int lat, w0;
      w0 = wr_beats;
      access(1'b1, a, d, rd, lat);
      chk(wr_beats - w0 == 1, "R7", "write beat count", 64'(wr_beats - w0), 64'd1);
      chk(last_wr_addr == {a[31:3], 3'b000}, "R7", "write address",
          64'(last_wr_addr), 64'({a[31:3], 3'b000}));
      chk(last_wr_data == d, "R7", "write data", last_wr_data, d);
   endtask

   task automatic t_reset;
      #5;
      chk(cpu_ready == 1'b0, "R1", "ready after reset", 64'(cpu_ready), 64'd0);
      chk(mem_req == 1'b0, "R1", "mem_req after reset", 64'(mem_req), 64'd0);
   endtask

   task automatic t_read_line;
      read_miss(32'h0000_0048, "R1");            // cold line: miss, R4/R5
      read_hit(32'h0000_0040, "R6");
      read_hit(32'h0000_0050, "R6");
      read_hit(32'h0000_0058, "R3");
      read_hit(32'h0000_004B, "R11");            // low bits ignored
   endtask

   task automatic t_conflict;
      read_miss(32'h0000_0448, "R2");            // same index, new tag
      read_miss(32'h0000_0048, "R2");            // original evicted
   endtask

   task automatic t_write_hit;
      write_through(32'h0000_0050, 64'hDEAD_BEEF_0123_4567);
      read_hit(32'h0000_0050, "R9");             // new data
      read_hit(32'h0000_0040, "R9");             // others still valid
      read_hit(32'h0000_0058, "R9");
   endtask

   task automatic t_write_miss;
      write_through(32'h0000_085D, 64'h1111_2222_3333_4444);
      read_hit(32'h0000_0858, "R8");             // written sub-block valid
      write_through(32'h0000_0848, 64'h5555_6666_7777_8888);
      read_hit(32'h0000_0858, "R9");             // earlier sub-block kept
      read_hit(32'h0000_0848, "R9");
      read_miss(32'h0000_0840, "R8");            // others were invalid
      read_hit(32'h0000_0858, "R8");             // fill sees written data
   endtask

   task automatic t_last_sub;
      busy_ready_seen = 1'b0;
      read_miss(32'h0000_00F8, "R5");            // requested word is last beat
      chk(!busy_ready_seen, "R10", "ready during fill", 64'(busy_ready_seen), 64'd0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++)
         model[i] = {16'hC0DE, 4'h0, 12'(i), 16'h5A5A ^ 16'(i * 3), 16'(i)};
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_read_line();
      t_conflict();
      t_write_hit();
      t_write_miss();
      t_last_sub();
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule